// File: doc/BRIEF.md
# Colour-Tagged Prefetch Filter

This block sits between an instruction prefetch queue and the decode stage. It removes instructions that were fetched down a path abandoned by a taken branch. It does this without any global flush wire. Each packet from the fetch side carries a one-bit stream colour and the program-counter value of its own word. The filter keeps a local colour. When execute reports a taken branch, the filter inverts the local colour and raises a new-stream request to the fetch side. That request carries the branch target and the new colour. From then on, every incoming packet whose colour does not match is consumed and thrown away. The filter never counts how many stale packets it expects, because the number in flight is not fixed.

In compressed mode, a fetched word holds two 16-bit instructions. The filter issues them as two separate instructions, lower halfword first. Each one carries its own PC, so later PC-relative operands never depend on a shared program counter. Every boundary is a valid/ready handshake.

Top module: `prefetch_colour_filter`

## Requirements
- R1: After reset the local colour is 0 and `out_valid` is low. A request is pending with `req_addr` equal to `reset_vec` and `req_colour` 0, and `br_ready` is low while that request waits.
- R2: A branch accepted on a clock edge (`br_valid` and `br_ready` both high) inverts the local colour. From the next cycle on, `req_valid` is high, `req_addr` equals the branch target and `req_colour` equals the new colour. The colour changes at no other time.
- R3: A pending request stays valid, with stable address and colour, until `req_ready` is high on a clock edge. While the request is pending, `br_ready` is low, so a waiting branch cannot invert the colour a second time.
- R4: A packet whose `in_colour` differs from the local colour is accepted (`in_ready` high) and discarded. Nothing is issued for it.
- R5: With `split_mode` low, each packet that matches the local colour is issued once, in arrival order. It appears with `out_instr` equal to the fetched word, `out_pc` equal to its `in_pc`, and `out_short` equal to 0.
- R6: With `split_mode` high, a matching word is issued as two instructions with `out_short` equal to 1. The first is bits 15:0 with `out_pc` equal to `in_pc`. The second is bits 31:16 with `out_pc` equal to `in_pc` + 2. In both, the halfword sits in the low 16 bits of `out_instr` and the upper bits are 0.
- R7: If a branch is accepted while the upper half of a split word is still waiting to issue, that upper half is never issued.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_instr`, `out_pc` and `out_short` hold their values.
- R9: Any number of stale packets is discarded after a branch, including none. The first packet of the new colour is then issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_vec | input | AW | Address of the first fetch after reset |
| split_mode | input | 1 | 1: each fetched word holds two 16-bit instructions |
| in_valid | input | 1 | Prefetch packet valid |
| in_ready | output | 1 | Filter accepts the packet |
| in_word | input | IW | Fetched instruction word |
| in_pc | input | AW | PC of the fetched word |
| in_colour | input | 1 | Stream colour of the packet |
| br_valid | input | 1 | Taken branch reported by execute |
| br_ready | output | 1 | Branch accepted |
| br_target | input | AW | Branch target address |
| req_valid | output | 1 | New-stream request to fetch |
| req_ready | input | 1 | Fetch takes the request |
| req_addr | output | AW | Start address of the requested stream |
| req_colour | output | 1 | Colour of the requested stream (the local colour) |
| out_valid | output | 1 | Issued instruction valid |
| out_ready | input | 1 | Decode takes the instruction |
| out_instr | output | IW | Issued instruction |
| out_pc | output | AW | PC of the issued instruction |
| out_short | output | 1 | 1: issued item is a 16-bit halfword |

## Verification
The bench drives a long stall on decode while a split word has its upper half waiting, then raises a branch. A filter that kept the upper half would issue an instruction from the abandoned path after the branch. Bursts of five stale packets, and a branch followed directly by new-colour packets, test for filters that discard a fixed count. Such a filter would either lose good instructions or let stale ones through. A second branch held while the first request is still unaccepted would, in a faulty design, invert the colour twice, and every packet of the real new stream would then be thrown away. Random back-pressure on the output exposes data that changes while it waits, and the upper-half PC offset catches a PC that is not advanced for the second half.

// File: rtl/pff_pkg.sv
package pff_pkg;
   // Source that feeds the issue register on a given cycle
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_WORD = 2'd1,
      SRC_HELD = 2'd2
   } issue_src_e;
endpackage

// File: rtl/pff_stream_ctl.sv
// Local colour and the single new-stream request slot.
module pff_stream_ctl #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] reset_vec,
   input  logic          br_valid,
   input  logic [AW-1:0] br_target,
   output logic          br_ready,
   output logic          br_fire,
   input  logic          req_ready,
   output logic          req_valid,
   output logic [AW-1:0] req_addr,
   output logic          colour
);
   logic          colour_q;
   logic          pend_q;
   logic          boot_q;
   logic [AW-1:0] tgt_q;

   // one outstanding request at a time: a second branch waits
   assign br_ready = !pend_q;
   assign br_fire  = br_valid && !pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         colour_q <= 1'b0;
         pend_q   <= 1'b1;
         boot_q   <= 1'b1;
         tgt_q    <= '0;
      end else if (br_fire) begin
         colour_q <= ~colour_q;
         pend_q   <= 1'b1;
         boot_q   <= 1'b0;
         tgt_q    <= br_target;
      end else if (pend_q && req_ready) begin
         pend_q <= 1'b0;
         boot_q <= 1'b0;
      end
   end

   assign req_valid = pend_q;
   assign req_addr  = boot_q ? reset_vec : tgt_q;
   assign colour    = colour_q;
endmodule

// File: rtl/pff_split_unit.sv
// Splits a fetched word into one or two issue items.
module pff_split_unit #(
   parameter int AW       = 32,
   parameter int IW       = 32,
   parameter bit SPLIT_EN = 1'b1
) (
   input  logic          split_mode,
   input  logic [IW-1:0] word,
   input  logic [AW-1:0] pc,
   output logic [IW-1:0] first_instr,
   output logic [AW-1:0] first_pc,
   output logic          first_short,
   output logic          second_valid,
   output logic [IW/2-1:0] second_half,
   output logic [AW-1:0] second_pc
);
   localparam int HW         = IW / 2;
   localparam int HALF_BYTES = HW / 8;

   assign first_pc  = pc;
   assign second_pc = pc + AW'(HALF_BYTES);

   generate
      if (SPLIT_EN) begin : g_split
         always_comb begin
            if (split_mode) begin
               first_instr  = {{HW{1'b0}}, word[HW-1:0]};
               first_short  = 1'b1;
               second_valid = 1'b1;
            end else begin
               first_instr  = word;
               first_short  = 1'b0;
               second_valid = 1'b0;
            end
            second_half = word[IW-1:HW];
         end
      end else begin : g_whole
         always_comb begin
            first_instr  = word;
            first_short  = 1'b0;
            second_valid = 1'b0;
            second_half  = '0;
         end
      end
   endgenerate
endmodule

// File: rtl/pff_issue_reg.sv
// Output register plus a one-entry holder for a pending upper halfword.
module pff_issue_reg
   import pff_pkg::*;
#(
   parameter int AW = 32,
   parameter int IW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            kill,
   input  logic            take_in,
   input  logic [IW-1:0]   first_instr,
   input  logic [AW-1:0]   first_pc,
   input  logic            first_short,
   input  logic            second_valid,
   input  logic [IW/2-1:0] second_half,
   input  logic [AW-1:0]   second_pc,
   input  logic            out_ready,
   output logic            out_valid,
   output logic [IW-1:0]   out_instr,
   output logic [AW-1:0]   out_pc,
   output logic            out_short,
   output logic            hold_busy,
   output logic            load_ok
);
   localparam int HW = IW / 2;

   logic            hold_v;
   logic [HW-1:0]   hold_data;
   logic [AW-1:0]   hold_pc;
   issue_src_e      sel;

   assign load_ok   = !out_valid || out_ready;
   assign hold_busy = hold_v;

   always_comb begin
      if (hold_v && !kill)
         sel = SRC_HELD;
      else if (take_in)
         sel = SRC_WORD;
      else
         sel = SRC_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_instr <= '0;
         out_pc    <= '0;
         out_short <= 1'b0;
         hold_v    <= 1'b0;
         hold_data <= '0;
         hold_pc   <= '0;
      end else begin
         if (load_ok) begin
            unique case (sel)
               SRC_HELD: begin
                  out_valid <= 1'b1;
                  out_instr <= {{HW{1'b0}}, hold_data};
                  out_pc    <= hold_pc;
                  out_short <= 1'b1;
                  hold_v    <= 1'b0;
               end
               SRC_WORD: begin
                  out_valid <= 1'b1;
                  out_instr <= first_instr;
                  out_pc    <= first_pc;
                  out_short <= first_short;
                  if (second_valid) begin
                     hold_v    <= 1'b1;
                     hold_data <= second_half;
                     hold_pc   <= second_pc;
                  end
               end
               default: out_valid <= 1'b0;
            endcase
         end
         // an accepted branch abandons the waiting upper half
         if (kill) hold_v <= 1'b0;
      end
   end
endmodule

// File: rtl/prefetch_colour_filter.sv
module prefetch_colour_filter #(
   parameter int AW       = 32,
   parameter int IW       = 32,
   parameter bit SPLIT_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] reset_vec,
   input  logic          split_mode,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [IW-1:0] in_word,
   input  logic [AW-1:0] in_pc,
   input  logic          in_colour,
   input  logic          br_valid,
   output logic          br_ready,
   input  logic [AW-1:0] br_target,
   output logic          req_valid,
   input  logic          req_ready,
   output logic [AW-1:0] req_addr,
   output logic          req_colour,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [IW-1:0] out_instr,
   output logic [AW-1:0] out_pc,
   output logic          out_short
);
   localparam int HW = IW / 2;

   generate
      if (IW % 16 != 0) begin : g_bad_iw
         $error("prefetch_colour_filter: IW must be a multiple of 16");
      end
      if (AW < 2) begin : g_bad_aw
         $error("prefetch_colour_filter: AW must be at least 2");
      end
   endgenerate

   logic          colour;
   logic          br_fire;
   logic          stale;
   logic          take_in;
   logic          load_ok;
   logic          hold_busy;
   logic [IW-1:0] first_instr;
   logic [AW-1:0] first_pc;
   logic          first_short;
   logic          second_valid;
   logic [HW-1:0] second_half;
   logic [AW-1:0] second_pc;

   pff_stream_ctl #(.AW(AW)) u_stream (
      .clk       (clk),
      .rst_n     (rst_n),
      .reset_vec (reset_vec),
      .br_valid  (br_valid),
      .br_target (br_target),
      .br_ready  (br_ready),
      .br_fire   (br_fire),
      .req_ready (req_ready),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .colour    (colour)
   );

   assign req_colour = colour;
   assign stale      = in_colour != colour;
   // matching packets stall on the branch cycle so they are judged against the new colour
   assign take_in    = in_valid && !stale && load_ok && !hold_busy && !br_fire;
   assign in_ready   = stale || (load_ok && !hold_busy && !br_fire);

   pff_split_unit #(.AW(AW), .IW(IW), .SPLIT_EN(SPLIT_EN)) u_split (
      .split_mode   (split_mode),
      .word         (in_word),
      .pc           (in_pc),
      .first_instr  (first_instr),
      .first_pc     (first_pc),
      .first_short  (first_short),
      .second_valid (second_valid),
      .second_half  (second_half),
      .second_pc    (second_pc)
   );

   pff_issue_reg #(.AW(AW), .IW(IW)) u_issue (
      .clk          (clk),
      .rst_n        (rst_n),
      .kill         (br_fire),
      .take_in      (take_in),
      .first_instr  (first_instr),
      .first_pc     (first_pc),
      .first_short  (first_short),
      .second_valid (second_valid),
      .second_half  (second_half),
      .second_pc    (second_pc),
      .out_ready    (out_ready),
      .out_valid    (out_valid),
      .out_instr    (out_instr),
      .out_pc       (out_pc),
      .out_short    (out_short),
      .hold_busy    (hold_busy),
      .load_ok      (load_ok)
   );
endmodule

// File: rtl/prefetch_colour_filter_chk.sv
module prefetch_colour_filter_chk #(
   parameter int AW = 32,
   parameter int IW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          in_ready,
   input logic          in_colour,
   input logic          br_valid,
   input logic          br_ready,
   input logic          req_valid,
   input logic          req_ready,
   input logic [AW-1:0] req_addr,
   input logic          req_colour,
   input logic          out_valid,
   input logic          out_ready,
   input logic [IW-1:0] out_instr,
   input logic [AW-1:0] out_pc,
   input logic          out_short
);
   assert_req_after_branch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && br_ready) |=> (req_valid && req_colour != $past(req_colour)));

   assert_colour_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(br_valid && br_ready) |=> $stable(req_colour));

   assert_no_branch_while_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !br_ready);

   assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_colour)));

   assert_stale_consumed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_colour != req_colour) |-> in_ready);

   assert_short_zero_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_short) |-> (out_instr[IW-1:IW/2] == '0));

   assert_out_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_instr) && $stable(out_pc)
                                     && $stable(out_short)));
endmodule

bind prefetch_colour_filter prefetch_colour_filter_chk #(.AW(AW), .IW(IW)) u_chk (.*);

// File: tb/prefetch_colour_filter_tb.sv
`timescale 1ns/1ps
module prefetch_colour_filter_tb;
   localparam int AW = 32;
   localparam int IW = 32;
   localparam logic [AW-1:0] RESET_VEC = 32'h0000_0100;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          split_mode = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [IW-1:0] in_word = '0;
   logic [AW-1:0] in_pc = '0;
   logic          in_colour = 1'b0;
   logic          br_valid = 1'b0;
   logic          br_ready;
   logic [AW-1:0] br_target = '0;
   logic          req_valid;
   logic          req_ready = 1'b0;
   logic [AW-1:0] req_addr;
   logic          req_colour;
   logic          out_valid;
   logic          out_ready = 1'b0;
   logic [IW-1:0] out_instr;
   logic [AW-1:0] out_pc;
   logic          out_short;

   always #4 clk = ~clk;

   prefetch_colour_filter #(.AW(AW), .IW(IW)) u_dut (
      .clk(clk), .rst_n(rst_n), .reset_vec(RESET_VEC), .split_mode(split_mode),
      .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .in_pc(in_pc),
      .in_colour(in_colour), .br_valid(br_valid), .br_ready(br_ready),
      .br_target(br_target), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_colour(req_colour), .out_valid(out_valid),
      .out_ready(out_ready), .out_instr(out_instr), .out_pc(out_pc), .out_short(out_short)
   );

   typedef struct packed {
      logic [IW-1:0] instr;
      logic [AW-1:0] pc;
      logic          sh;
   } exp_t;

   exp_t  exp_q[$];
   exp_t  got;
   int    n_checks = 0;
   int    n_fail = 0;
   logic  mcol = 1'b0;
   string cur_tag = "R5";
   int    rdy_mode = 0;      // 0 random, 1 held low, 2 held high
   logic [7:0] lfsr = 8'h5a;
   logic  was_held = 1'b0;
   logic [IW-1:0] h_instr;
   logic [AW-1:0] h_pc;
   logic  h_short;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // decode-side back-pressure
   always @(posedge clk) begin
      #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (rdy_mode)
         1:       out_ready = 1'b0;
         2:       out_ready = 1'b1;
         default: out_ready = lfsr[0] | lfsr[3];
      endcase
   end

   // monitor: scoreboard compare and hold-stability check
   always @(negedge clk) begin
      if (rst_n) begin
         if (was_held) begin
            chk(out_valid && out_instr == h_instr && out_pc == h_pc && out_short == h_short,
                "R8 held output changed", {out_instr, out_pc}, {h_instr, h_pc});
         end
         was_held = out_valid && !out_ready;
         h_instr  = out_instr;
         h_pc     = out_pc;
         h_short  = out_short;
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, {cur_tag, " unexpected issue"}, {out_instr, out_pc}, 64'h0);
            end else begin
               got = exp_q.pop_front();
               chk(out_instr == got.instr && out_pc == got.pc && out_short == got.sh,
                   cur_tag, {out_instr, out_pc}, {got.instr, got.pc});
            end
         end
      end
   end

   // driver: called and returns at posedge + 1 ns
   task automatic send(input logic [IW-1:0] w, input logic [AW-1:0] pc, input logic c);
      in_valid  = 1'b1;
      in_word   = w;
      in_pc     = pc;
      in_colour = c;
      if (c == mcol) begin
         if (split_mode) begin
            exp_q.push_back('{instr: {16'h0, w[15:0]}, pc: pc, sh: 1'b1});
            exp_q.push_back('{instr: {16'h0, w[31:16]}, pc: pc + 32'd2, sh: 1'b1});
         end else begin
            exp_q.push_back('{instr: w, pc: pc, sh: 1'b0});
         end
      end
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic branch(input logic [AW-1:0] t);
      br_valid  = 1'b1;
      br_target = t;
      do @(negedge clk); while (!br_ready);
      @(posedge clk); #1;
      br_valid = 1'b0;
      mcol = ~mcol;
      @(negedge clk);
      chk(req_valid && req_addr == t, "R2 request target", {31'h0, req_valid, req_addr},
          {32'h1, t});
      chk(req_colour == mcol, "R2 request colour", 64'(req_colour), 64'(mcol));
      chk(!br_ready, "R3 branch blocked while pending", 64'(br_ready), 64'h0);
      @(posedge clk); #1;
   endtask

   task automatic accept_req();
      req_ready = 1'b1;
      @(posedge clk); #1;
      req_ready = 1'b0;
   endtask

   task automatic drain();
      rdy_mode = 2;
      for (int i = 0; i < 200 && (exp_q.size() != 0 || out_valid); i++) begin
         @(posedge clk); #1;
      end
      chk(exp_q.size() == 0, {cur_tag, " drain"}, 64'(exp_q.size()), 64'h0);
      rdy_mode = 0;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      n_fail++;
      $display("FAIL R5 watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!out_valid, "R1 out_valid", 64'(out_valid), 64'h0);
      chk(req_valid && req_addr == RESET_VEC, "R1 boot request",
          {31'h0, req_valid, req_addr}, {32'h1, RESET_VEC});
      chk(req_colour == 1'b0, "R1 colour", 64'(req_colour), 64'h0);
      chk(!br_ready, "R1 branch blocked", 64'(br_ready), 64'h0);
      @(posedge clk); #1;
      // R3 request held while fetch is not ready
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(req_valid && req_addr == RESET_VEC && req_colour == 1'b0, "R3 request held",
             {31'h0, req_valid, req_addr}, {32'h1, RESET_VEC});
      end
      @(posedge clk); #1;
      accept_req();
      @(negedge clk);
      chk(!req_valid && br_ready, "R3 slot freed", {req_valid, br_ready}, 64'h1);
      @(posedge clk); #1;

      // R5 full-width words under random back-pressure
      cur_tag = "R5";
      split_mode = 1'b0;
      for (int i = 0; i < 8; i++)
         send(32'hA000_0000 + i * 32'h0101_0003, RESET_VEC + i * 4, mcol);
      drain();

      // R6 split words
      cur_tag = "R6";
      split_mode = 1'b1;
      for (int i = 0; i < 6; i++)
         send(32'hB1C0_0D00 + i * 32'h0011_0022, 32'h0000_0200 + i * 4, mcol);
      drain();

      // R4 and R9: branch, five stale packets, then the new stream
      cur_tag = "R4";
      split_mode = 1'b0;
      branch(32'h0000_2000);
      accept_req();
      for (int i = 0; i < 5; i++) begin
         send(32'hDEAD_0000 + i, 32'h0000_0300 + i * 4, ~mcol);
         @(negedge clk);
         chk(!out_valid, "R4 stale not issued", 64'(out_valid), 64'h0);
         @(posedge clk); #1;
      end
      cur_tag = "R9";
      for (int i = 0; i < 4; i++)
         send(32'hC000_0000 + i * 32'h10, 32'h0000_2000 + i * 4, mcol);
      drain();

      // R9: branch with no stale packets at all
      branch(32'h0000_3000);
      accept_req();
      for (int i = 0; i < 3; i++)
         send(32'hC100_0000 + i, 32'h0000_3000 + i * 4, mcol);
      drain();

      // R7: branch while an upper half is pending
      cur_tag = "R7";
      rdy_mode = 1;
      split_mode = 1'b1;
      @(posedge clk); #1;
      send(32'h7777_1111, 32'h0000_4000, mcol);
      repeat (3) @(posedge clk);
      #1;
      branch(32'h0000_5000);
      void'(exp_q.pop_back());
      accept_req();
      split_mode = 1'b0;
      rdy_mode = 2;
      send(32'h5555_AAAA, 32'h0000_5000, mcol);
      drain();

      // R3: second branch waits, colour inverts once per accepted branch
      cur_tag = "R3";
      branch(32'h0000_6000);
      br_valid  = 1'b1;
      br_target = 32'h0000_7000;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(!br_ready && req_colour == mcol && req_addr == 32'h0000_6000,
             "R3 second branch held", {31'h0, br_ready, req_addr}, {32'h0, 32'h0000_6000});
      end
      @(posedge clk); #1;
      req_ready = 1'b1;
      @(posedge clk); #1;   // request taken; branch fires on the next edge
      req_ready = 1'b0;
      @(posedge clk); #1;
      br_valid = 1'b0;
      mcol = ~mcol;
      @(negedge clk);
      chk(req_valid && req_colour == mcol && req_addr == 32'h0000_7000,
          "R3 second branch taken once", {31'h0, req_colour, req_addr},
          {31'h0, mcol, 32'h0000_7000});
      @(posedge clk); #1;
      accept_req();
      send(32'h0000_0BAD, 32'h0000_6000, ~mcol);
      send(32'h1234_5678, 32'h0000_7000, mcol);
      drain();

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule